// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Turnaround Idle State

This block runs bus cycles on a memory-mapped external bus divided into numbered areas, each with its own chip select. A requester hands over an access through a ready/valid port: area number, direction, address and write data. The block then drives the address, the chip select of that area, the read or write strobe and the write data over a fixed number of bus states. When the cycle finishes, it returns a done pulse with the captured read data.

A device with a long output float time can still be driving the data bus when the next device starts. To prevent this, the block can place one quiet state ahead of a cycle. During that state no chip select and no strobe is active. The quiet state is added in two cases, and each case has its own enable. The first case is a read that directly follows a read to a different area. This case also requires the extended addressing mode input. The second case is a write that directly follows a read.

"Directly follows" means the request was accepted in the final state of the previous cycle. A request accepted while the bus is already idle starts without an extra state.

Top module: `ext_bus_idle_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, and bus_cs_o, bus_rd_o, bus_wr_o and rsp_done_o are all 0.
- R2: A bus cycle lasts NSTATE states (3 by default). The chip select bit whose index equals the area number is high in every state of the cycle, and bus_addr_o carries the request address. For a read, bus_rd_o is high in every state except the first. For a write, bus_wr_o is high in the states between the first and the last (one state by default). Write data is driven with bus_wdata_oe_o.
- R3: Both enables reset to 1. They are reloaded together from cfg_rr_en_i and cfg_wr_en_i when cfg_we_i is 1.
- R4: A read that directly follows a read to a different area gets exactly one idle state ahead of it, provided that both the read-read enable and adv_mode_i are 1.
- R5: A write that directly follows a read gets exactly one idle state when the write-after-read enable is 1. This holds regardless of adv_mode_i.
- R6: These pairs never get an idle state: a read after a read to the same area, a write after a write, and a read after a write.
- R7: When the read-read enable is 0, a read that follows a read to a different area gets no idle state.
- R8: When adv_mode_i is 0, the read-read idle state is suppressed. The write-after-read idle state is unaffected.
- R9: When the write-after-read enable is 0, a write that follows a read gets no idle state.
- R10: During an idle state, no chip select and no strobe is active. A request accepted while the bus is already idle gets no additional idle state; this includes the first access after reset.
- R11: req_ready_o is 0 during an idle state and during every state of a cycle except its last. rsp_done_o pulses for one clock in the clock after the final state. rsp_rdata_o then holds the value of bus_rdata_i sampled in the final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_mode_i | input | 1 | Extended addressing mode; permits the read-read idle state |
| cfg_we_i | input | 1 | Load strobe for the two enables |
| cfg_rr_en_i | input | 1 | New value of the read-read enable |
| cfg_wr_en_i | input | 1 | New value of the write-after-read enable |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted on this edge if valid |
| req_area_i | input | $clog2(AREAS) | Target area number |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| rsp_done_o | output | 1 | Cycle completed pulse |
| rsp_rdata_o | output | DW | Captured read data |
| bus_addr_o | output | AW | External address |
| bus_cs_o | output | AREAS | Chip selects, one per area, active high |
| bus_rd_o | output | 1 | Read strobe, active high |
| bus_wr_o | output | 1 | Write strobe, active high |
| bus_wdata_o | output | DW | External write data |
| bus_wdata_oe_o | output | 1 | Write data output enable |
| bus_rdata_i | input | DW | External read data |

## Verification
The hardest case to produce is a true back-to-back pair. The second request must already be valid and held while the first cycle is in its final state, because otherwise the bus passes through an ordinary idle state and the turnaround logic is never exercised. The stimulus therefore presents the second request at the first falling edge after the first one is accepted and keeps it valid until it is taken. A monitor then measures the chip-select span and the number of quiet states inside it. One variant deliberately waits for the done pulse before the second request, which shows that an already idle bus does not get a second gap.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_ACT  = 2'd2
  } bus_st_e;
endpackage

// File: rtl/ebi_gap_decide.sv
module ebi_gap_decide #(
  parameter int AREA_W = 3
) (
  input  logic              back2back_i,
  input  logic              prev_vld_i,
  input  logic [AREA_W-1:0] prev_area_i,
  input  logic              prev_write_i,
  input  logic [AREA_W-1:0] next_area_i,
  input  logic              next_write_i,
  input  logic              rr_en_i,
  input  logic              wr_en_i,
  input  logic              adv_mode_i,
  output logic              need_gap_o
);
  logic after_read;
  logic rr_case;
  logic wr_case;

  assign after_read = back2back_i && prev_vld_i && !prev_write_i;
  assign rr_case    = !next_write_i && (next_area_i != prev_area_i) && rr_en_i && adv_mode_i;
  assign wr_case    = next_write_i && wr_en_i;
  assign need_gap_o = after_read && (rr_case || wr_case);
endmodule

// File: rtl/ebi_cs_decode.sv
module ebi_cs_decode #(
  parameter int AREAS  = 8,
  parameter int AREA_W = 3
) (
  input  logic              en_i,
  input  logic [AREA_W-1:0] area_i,
  output logic [AREAS-1:0]  cs_o
);
  for (genvar i = 0; i < AREAS; i++) begin : g_cs
    assign cs_o[i] = en_i && (area_i == AREA_W'(i));
  end
endmodule

// File: rtl/ext_bus_idle_ctrl.sv
module ext_bus_idle_ctrl #(
  parameter int AREAS  = 8,
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int NSTATE = 3,
  localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_mode_i,
  input  logic              cfg_we_i,
  input  logic              cfg_rr_en_i,
  input  logic              cfg_wr_en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AREA_W-1:0] req_area_i,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_done_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [AREAS-1:0]  bus_cs_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DW-1:0]     bus_wdata_o,
  output logic              bus_wdata_oe_o,
  input  logic [DW-1:0]     bus_rdata_i
);
  import ebi_pkg::*;

  localparam int CW = (NSTATE > 1) ? $clog2(NSTATE) : 1;
  localparam logic [CW-1:0] T_LAST = CW'(NSTATE - 1);

  bus_st_e           state_q;
  logic [CW-1:0]     tcnt_q;
  logic [AREA_W-1:0] area_q;
  logic              write_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic              prev_vld_q;
  logic              rr_en_q;
  logic              wr_en_q;
  logic              done_q;
  logic [DW-1:0]     rdata_q;

  logic active;
  logic last_st;
  logic accept;
  logic need_gap;

  assign active      = (state_q == ST_ACT);
  assign last_st     = active && (tcnt_q == T_LAST);
  assign req_ready_o = (state_q == ST_IDLE) || last_st;
  assign accept      = req_valid_i && req_ready_o;

  ebi_gap_decide #(.AREA_W(AREA_W)) u_decide (
    .back2back_i (last_st),
    .prev_vld_i  (prev_vld_q),
    .prev_area_i (area_q),
    .prev_write_i(write_q),
    .next_area_i (req_area_i),
    .next_write_i(req_write_i),
    .rr_en_i     (rr_en_q),
    .wr_en_i     (wr_en_q),
    .adv_mode_i  (adv_mode_i),
    .need_gap_o  (need_gap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_en_q <= 1'b1;
      wr_en_q <= 1'b1;
    end else if (cfg_we_i) begin
      rr_en_q <= cfg_rr_en_i;
      wr_en_q <= cfg_wr_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tcnt_q     <= '0;
      area_q     <= '0;
      write_q    <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      prev_vld_q <= 1'b0;
    end else if (accept) begin
      area_q     <= req_area_i;
      write_q    <= req_write_i;
      addr_q     <= req_addr_i;
      wdata_q    <= req_wdata_i;
      prev_vld_q <= 1'b1;
      tcnt_q     <= '0;
      state_q    <= need_gap ? ST_GAP : ST_ACT;
    end else begin
      case (state_q)
        ST_GAP:  state_q <= ST_ACT;
        ST_ACT: begin
          if (last_st) state_q <= ST_IDLE;
          else         tcnt_q  <= tcnt_q + CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // read data is captured in the final state, done follows one clock later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= last_st;
      if (last_st && !write_q) rdata_q <= bus_rdata_i;
    end
  end

  ebi_cs_decode #(.AREAS(AREAS), .AREA_W(AREA_W)) u_cs (
    .en_i  (active),
    .area_i(area_q),
    .cs_o  (bus_cs_o)
  );

  assign bus_rd_o       = active && !write_q && (tcnt_q != '0);
  assign bus_wr_o       = active && write_q && (tcnt_q != '0) &&
                          ((tcnt_q != T_LAST) || (NSTATE == 2));
  assign bus_addr_o     = addr_q;
  assign bus_wdata_o    = wdata_q;
  assign bus_wdata_oe_o = active && write_q;
  assign rsp_done_o     = done_q;
  assign rsp_rdata_o    = rdata_q;
endmodule

// File: rtl/ext_bus_idle_ctrl_chk.sv
module ext_bus_idle_ctrl_chk #(
  parameter int AREAS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input ebi_pkg::bus_st_e state_q,
  input logic             last_st,
  input logic             accept,
  input logic             need_gap,
  input logic             req_ready_o,
  input logic             rsp_done_o,
  input logic [AREAS-1:0] bus_cs_o,
  input logic             bus_rd_o,
  input logic             bus_wr_o
);
  import ebi_pkg::*;

  a_r2_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_cs_o));

  a_r2_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  a_r2_cs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT && !last_st) |=> $stable(bus_cs_o));

  a_r10_gap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> (bus_cs_o == '0 && !bus_rd_o && !bus_wr_o));

  a_r10_gap_one_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> (state_q == ST_ACT));

  a_r10_idle_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && state_q == ST_IDLE) |=> (state_q == ST_ACT));

  a_r4_gap_follows_decision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && need_gap) |=> (state_q == ST_GAP));

  a_r11_ready_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> !req_ready_o);

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  a_r11_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_st |=> rsp_done_o);
endmodule

bind ext_bus_idle_ctrl ext_bus_idle_ctrl_chk #(.AREAS(AREAS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_q    (state_q),
  .last_st    (last_st),
  .accept     (accept),
  .need_gap   (need_gap),
  .req_ready_o(req_ready_o),
  .rsp_done_o (rsp_done_o),
  .bus_cs_o   (bus_cs_o),
  .bus_rd_o   (bus_rd_o),
  .bus_wr_o   (bus_wr_o)
);

// File: tb/ext_bus_idle_ctrl_tb.sv
`timescale 1ns/1ps
module ext_bus_idle_ctrl_tb;
  localparam int AREAS = 8;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv_mode, cfg_we, cfg_rr, cfg_wr;
  logic req_valid, req_ready, req_write;
  logic [2:0] req_area;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic [AREAS-1:0] bus_cs;
  logic bus_rd, bus_wr, bus_oe;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  ext_bus_idle_ctrl #(.AREAS(AREAS), .AW(AW), .DW(DW), .NSTATE(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .adv_mode_i(adv_mode),
    .cfg_we_i(cfg_we), .cfg_rr_en_i(cfg_rr), .cfg_wr_en_i(cfg_wr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_area_i(req_area),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata), .bus_addr_o(bus_addr),
    .bus_cs_o(bus_cs), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
    .bus_wdata_o(bus_wdata), .bus_wdata_oe_o(bus_oe), .bus_rdata_i(bus_rdata)
  );

  // monitor
  bit mon_en = 0;
  int cyc, first_c, last_c, cs_cnt, rd_cnt, wr_cnt, quiet_bad;
  logic [AREAS-1:0] first_cs;
  logic [AW-1:0] first_addr;

  always @(negedge clk) if (mon_en) begin
    if (bus_cs != '0) begin
      if (first_c < 0) begin
        first_c = cyc; first_cs = bus_cs; first_addr = bus_addr;
      end
      last_c = cyc;
      cs_cnt++;
    end else if (bus_rd || bus_wr) quiet_bad++;
    if (bus_rd) rd_cnt++;
    if (bus_wr) wr_cnt++;
    cyc++;
  end

  task automatic mon_clear();
    cyc = 0; first_c = -1; last_c = -1; cs_cnt = 0; rd_cnt = 0; wr_cnt = 0; quiet_bad = 0;
    first_cs = '0; first_addr = '0;
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance with valid still high
  task automatic issue(input logic [2:0] a, input logic w, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    req_area = a; req_write = w; req_addr = ad; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_pair(input string req, input logic [2:0] a1, input logic w1,
                          input logic [2:0] a2, input logic w2, input logic spaced, input int gap);
    mon_clear();
    mon_en = 1;
    issue(a1, w1, 24'h100 + AW'(a1), 16'h1111);
    if (spaced) begin
      req_valid = 1'b0;
      while (!rsp_done) @(negedge clk);
    end
    issue(a2, w2, 24'h200 + AW'(a2), 16'h2222);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    mon_en = 0;
    check(req, "span", last_c - first_c + 1, 2 * NS + gap);
    check(req, "quiet states", (last_c - first_c + 1) - cs_cnt, gap);
    check(req, "strobe while quiet", quiet_bad, 0);
    check(req, "first cs", first_cs, 1 << a1);
    check(req, "first addr", first_addr, 24'h100 + a1);
    check(req, "rd states", rd_cnt, (w1 ? 0 : NS - 1) + (w2 ? 0 : NS - 1));
    check(req, "wr states", wr_cnt, (w1 ? NS - 2 : 0) + (w2 ? NS - 2 : 0));
  endtask

  // {a1, w1, a2, w2, rr_en, wr_en, adv, spaced, 2'b0, gap}
  localparam logic [15:0] VEC [10] = '{
    {3'd1, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd1},  // R4
    {3'd3, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0},  // R6 same area
    {3'd1, 1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd1},  // R5
    {3'd2, 1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0},  // R6 w-w
    {3'd2, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0},  // R6 w-r
    {3'd1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0},  // R7
    {3'd1, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'd0},  // R8 rr off
    {3'd1, 1'b0, 3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2'd0},  // R9
    {3'd1, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 2'd1},  // R10 already idle
    {3'd0, 1'b0, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'd1}   // R8 wr unaffected
  };
  localparam string VREQ [10] = '{"R4", "R6", "R5", "R6", "R6", "R7", "R8", "R9", "R10", "R8"};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    adv_mode = 1'b1; cfg_we = 1'b0; cfg_rr = 1'b0; cfg_wr = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_area = '0; req_addr = '0; req_wdata = '0;
    bus_rdata = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ready", req_ready, 1);
    check("R1", "cs", bus_cs, 0);
    check("R1", "rd/wr", {bus_rd, bus_wr}, 0);
    check("R1", "done", rsp_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after release", req_ready, 1);

    // R3 default enables: read-read gap without any configuration
    run_pair("R3", 3'd4, 1'b0, 3'd5, 1'b0, 1'b0, 1);
    run_pair("R3", 3'd4, 1'b0, 3'd4, 1'b1, 1'b0, 1);

    // R11 read data capture, ready low mid-cycle, done pulse
    bus_rdata = 16'h5A3C;
    issue(3'd6, 1'b0, 24'h00ABCD, 16'h0);
    req_valid = 1'b0;
    check("R11", "ready in first state", req_ready, 0);
    check("R2", "addr", bus_addr, 24'h00ABCD);
    @(negedge clk);
    check("R11", "ready in middle state", req_ready, 0);
    @(negedge clk);
    check("R11", "ready in last state", req_ready, 1);
    check("R11", "done before end", rsp_done, 0);
    @(negedge clk);
    bus_rdata = 16'h0;
    check("R11", "done pulse", rsp_done, 1);
    check("R11", "rdata", rsp_rdata, 16'h5A3C);
    @(negedge clk);
    check("R11", "done one clock", rsp_done, 0);

    // R2 write data on bus
    issue(3'd3, 1'b1, 24'h000321, 16'hBEEF);
    req_valid = 1'b0;
    check("R2", "wdata", bus_wdata, 16'hBEEF);
    check("R2", "wdata oe", bus_oe, 1);
    repeat (4) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      cfg_rr = VEC[i][7]; cfg_wr = VEC[i][6]; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      adv_mode = VEC[i][5];
      run_pair(VREQ[i], VEC[i][15:13], VEC[i][12], VEC[i][11:9], VEC[i][8], VEC[i][4], int'(VEC[i][1:0]));
    end

    // R10 first access after reset gets no gap even if issued right away
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_pair("R10", 3'd1, 1'b0, 3'd1, 1'b1, 1'b0, 1);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule